// File: doc/BRIEF.md
# Multiplexed Clock Display Scanner

This block drives a time display made of four common-cathode digits and a colon. Only one position is lit at any moment. A scan index steps through the four digits and then the colon, one step per scan-rate enable pulse. At a 1 kHz enable rate each position is refreshed at about 200 Hz, which is too fast for the eye to see as flicker. For the current position the block picks a 4-bit code, turns it into a segment pattern and pulls that position's cathode low. It leaves every other cathode undriven.

The four digit codes come from outside as BCD nibbles: hours tens, hours units, minutes tens, minutes units. The colon position gets a code that the block makes itself. That code alternates between a lit colon and a dark one. It changes on each one-second tick, so the colon blinks. Just after every step of the scan index the segments are forced dark for a short guard window. This stops the previous digit from briefly showing on the new cathode.

Top module: `clock_display_scan`

## Requirements
- R1: While `rst_n` is low and right after it is released, the scan index is 0 (only `cath_oe_o[0]` is set), the blink phase is off and no guard window is active, so `seg_o` at once shows the decoded slot-0 digit.
- R2: The scan index goes up by one on the clock edge after a cycle with `scan_en` high. It runs 0,1,2,3,4 and then wraps to 0. It holds when `scan_en` is low.
- R3: Exactly one bit of `cath_oe_o` is 1, and it is the bit of the current scan index. `cath_drive_o` is all zeros, so the enabled cathode is pulled low and every other cathode is released to high impedance.
- R4: Scan slot k for k from 0 to 3 shows `digits_i[4k+3:4k]`. Slot 0 is hours tens, slot 1 is hours units, slot 2 is minutes tens and slot 3 is minutes units.
- R5: `seg_o[7]` is segment A, then B, C, D, E, F and G down to `seg_o[1]`, and `seg_o[0]` is DP. A 1 lights a segment. Codes 0 to 9 give 0xFC, 0x60, 0xDA, 0xF2, 0x66, 0xB6, 0xBE, 0xE0, 0xFE and 0xF6.
- R6: Slot 4 is the colon. It is fed code 4'b1111 while the blink phase is on, which gives `seg_o` = 0xC0 (segments A and B only). It is fed code 4'b1110 while the phase is off, which gives 0x00.
- R7: Codes 10 to 14 decode to 0x00 in any slot. Code 15 decodes to 0xC0 in any slot.
- R8: The blink phase flips on the edge after each cycle with `blink_tick` high. This does not depend on `scan_en`.
- R9: For `GUARD_CYCLES` clock cycles after each step of the scan index, `seg_o` is 0x00. A new step during the window starts the window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Single-cycle scan-rate enable that steps the scan index |
| blink_tick | input | 1 | Single-cycle one-second tick that flips the colon phase |
| digits_i | input | 4*NUM_DIGITS | BCD digit codes, slot k in bits [4k+3:4k] |
| seg_o | output | 8 | Segment pattern, A in bit 7 down to DP in bit 0, active high |
| cath_drive_o | output | NUM_DIGITS+1 | Cathode drive level, always low |
| cath_oe_o | output | NUM_DIGITS+1 | Cathode output enable, one-hot on the lit slot |

## Verification
The assertions take `scan_en` and `blink_tick` to be known values at every clock edge after reset. They accept pulses in back-to-back cycles as well as isolated ones. They do not require `scan_en` to be spaced wider than the guard window, because a new step only restarts the blanking. The bench keeps every input at a defined value from time zero and changes inputs only on the falling edge. It covers three patterns: steps spaced well apart, steps in consecutive cycles, and random steps and ticks mixed with arbitrary digit nibbles, including codes that are not valid BCD.

// File: rtl/clkdisp_pkg.sv
package clkdisp_pkg;
    typedef logic [3:0] code_t;
    typedef logic [7:0] seg_t;

    localparam code_t COLON_LIT  = 4'b1111;
    localparam code_t COLON_DARK = 4'b1110;
    localparam seg_t  SEG_OFF    = 8'h00;
endpackage

// File: rtl/clkdisp_code_sel.sv
module clkdisp_code_sel
    import clkdisp_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int IDX_W      = 3
) (
    input  logic [4*NUM_DIGITS-1:0] digits_i,
    input  logic [IDX_W-1:0]        slot_i,
    input  logic                    colon_on_i,
    output code_t                   code_o
);
    always_comb begin
        code_o = colon_on_i ? COLON_LIT : COLON_DARK;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (slot_i == IDX_W'(k)) begin
                code_o = digits_i[4*k +: 4];
            end
        end
    end
endmodule

// File: rtl/clkdisp_seg_decode.sv
module clkdisp_seg_decode
    import clkdisp_pkg::*;
(
    input  code_t code_i,
    output seg_t  seg_o
);
    always_comb begin
        unique case (code_i)
            4'd0:    seg_o = 8'hFC;
            4'd1:    seg_o = 8'h60;
            4'd2:    seg_o = 8'hDA;
            4'd3:    seg_o = 8'hF2;
            4'd4:    seg_o = 8'h66;
            4'd5:    seg_o = 8'hB6;
            4'd6:    seg_o = 8'hBE;
            4'd7:    seg_o = 8'hE0;
            4'd8:    seg_o = 8'hFE;
            4'd9:    seg_o = 8'hF6;
            4'd15:   seg_o = 8'hC0;
            default: seg_o = SEG_OFF;
        endcase
    end
endmodule

// File: rtl/clkdisp_cathode.sv
module clkdisp_cathode #(
    parameter int SLOTS = 5,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] slot_i,
    output logic [SLOTS-1:0] drive_o,
    output logic [SLOTS-1:0] oe_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cath
        assign oe_o[g]    = (slot_i == IDX_W'(g));
        assign drive_o[g] = 1'b0;
    end
endmodule

// File: rtl/clock_display_scan.sv
module clock_display_scan
    import clkdisp_pkg::*;
#(
    parameter int NUM_DIGITS   = 4,
    parameter int GUARD_CYCLES = 2,
    localparam int SLOTS       = NUM_DIGITS + 1,
    localparam int IDX_W       = $clog2(SLOTS),
    localparam int GRD_W       = $clog2(GUARD_CYCLES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic                    blink_tick,
    input  logic [4*NUM_DIGITS-1:0] digits_i,
    output logic [7:0]              seg_o,
    output logic [SLOTS-1:0]        cath_drive_o,
    output logic [SLOTS-1:0]        cath_oe_o
);
    typedef struct packed {
        logic [IDX_W-1:0] slot;
        logic [GRD_W-1:0] guard;
        logic             blink;
    } state_t;

    state_t st_d, st_q;
    code_t  code_w;
    seg_t   seg_w;

    always_comb begin
        st_d = st_q;
        if (scan_en) begin
            st_d.slot  = (st_q.slot == IDX_W'(SLOTS - 1)) ? '0 : st_q.slot + 1'b1;
            st_d.guard = GRD_W'(GUARD_CYCLES);
        end else if (st_q.guard != '0) begin
            st_d.guard = st_q.guard - 1'b1;
        end
        if (blink_tick) begin
            st_d.blink = ~st_q.blink;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    clkdisp_code_sel #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) u_code_sel (
        .digits_i  (digits_i),
        .slot_i    (st_q.slot),
        .colon_on_i(st_q.blink),
        .code_o    (code_w)
    );

    clkdisp_seg_decode u_decode (
        .code_i(code_w),
        .seg_o (seg_w)
    );

    clkdisp_cathode #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_cathode (
        .slot_i (st_q.slot),
        .drive_o(cath_drive_o),
        .oe_o   (cath_oe_o)
    );

    assign seg_o = (st_q.guard != '0) ? SEG_OFF : seg_w;
endmodule

// File: rtl/clock_display_scan_chk.sv
module clock_display_scan_chk #(
    parameter int SLOTS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_en,
    input logic [7:0]       seg_o,
    input logic [SLOTS-1:0] cath_oe_o
);
    p_one_cathode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cath_oe_o) == 1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !cath_oe_o[SLOTS-1]) |=> cath_oe_o == ($past(cath_oe_o) << 1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && cath_oe_o[SLOTS-1]) |=> cath_oe_o[0]);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(cath_oe_o));

    p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> seg_o == 8'h00);

    p_colon_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cath_oe_o[SLOTS-1] && seg_o != 8'h00) |-> seg_o == 8'hC0);
endmodule

bind clock_display_scan clock_display_scan_chk #(.SLOTS(NUM_DIGITS + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .seg_o    (seg_o),
    .cath_oe_o(cath_oe_o)
);

// File: tb/clock_display_scan_bench.sv
module clock_display_scan_bench;
    localparam int ND    = 4;
    localparam int NS    = ND + 1;
    localparam int GUARD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scan_en = 1'b0;
    logic          blink_tick = 1'b0;
    logic [4*ND-1:0] digits = 16'h0000;
    logic [7:0]    seg;
    logic [NS-1:0] drv;
    logic [NS-1:0] oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_slot  = 0;
    int m_guard = 0;
    bit m_blink = 0;

    always #4 clk = ~clk;

    clock_display_scan #(.NUM_DIGITS(ND), .GUARD_CYCLES(GUARD)) u_clock_display_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_en     (scan_en),
        .blink_tick  (blink_tick),
        .digits_i    (digits),
        .seg_o       (seg),
        .cath_drive_o(drv),
        .cath_oe_o   (oe)
    );

    function automatic logic [7:0] shape(input int c);
        logic [7:0] s;
        case (c)
            0: s = 8'hFC;  1: s = 8'h60;  2: s = 8'hDA;  3: s = 8'hF2;
            4: s = 8'h66;  5: s = 8'hB6;  6: s = 8'hBE;  7: s = 8'hE0;
            8: s = 8'hFE;  9: s = 8'hF6;  15: s = 8'hC0;
            default: s = 8'h00;
        endcase
        return s;
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_guard = 0; m_blink = 0;
        end else begin
            if (scan_en) begin
                m_slot  = (m_slot + 1) % NS;
                m_guard = GUARD;
            end else if (m_guard > 0) begin
                m_guard = m_guard - 1;
            end
            if (blink_tick) m_blink = !m_blink;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string extra);
        int code;
        logic [7:0] es;
        string tag;
        code = (m_slot < ND) ? int'(digits[4*m_slot +: 4]) : (m_blink ? 15 : 14);
        es   = (m_guard > 0) ? 8'h00 : shape(code);
        if (m_guard > 0)               tag = "R9";
        else if (m_slot == ND)         tag = "R6 R8";
        else if (code > 9)             tag = "R7 R4";
        else                           tag = "R5 R4";
        chk(seg == es, {tag, " seg ", extra}, int'(seg), int'(es));
        chk(oe == NS'(1 << m_slot), {"R2 R3 oe ", extra}, int'(oe), 1 << m_slot);
        chk(drv == '0, {"R3 drive ", extra}, int'(drv), 0);
    endtask

    task automatic step(input bit se, input bit bt, input string extra);
        scan_en = se;
        blink_tick = bt;
        @(posedge clk);
        @(negedge clk);
        compare(extra);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        digits = 16'h3921;
        repeat (3) @(negedge clk);
        chk(oe == 5'b00001, "R1 oe in reset", int'(oe), 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: slot 0 digit 1, no guard
        chk(seg == 8'h60, "R1 seg after reset", int'(seg), 8'h60);
        compare("R1 reset");

        // R2 R4 R5: spaced steps through all slots twice
        for (int i = 0; i < 2 * NS; i++) begin
            step(1'b1, 1'b0, "spaced");
            for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "spaced");
        end

        // R6 R8: colon blink with ticks, park on colon slot
        while (m_slot != ND) step(1'b1, 1'b0, "to colon");
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "settle");
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, "tick");
            chk(seg == (m_blink ? 8'hC0 : 8'h00), "R6 R8 colon phase", int'(seg),
                m_blink ? 8'hC0 : 8'h00);
            step(1'b0, 1'b0, "tick hold");
        end

        // R7: non-BCD codes in digit slots
        digits = 16'hFEBA;
        for (int i = 0; i < NS; i++) begin
            step(1'b1, 1'b1, "invalid");
            for (int j = 0; j < 3; j++) step(1'b0, 1'b0, "invalid");
        end

        // R9: back-to-back steps keep renewing the guard
        digits = 16'h8888;
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "burst");
        for (int j = 0; j < 4; j++) step(1'b0, 1'b0, "burst end");

        // mixed random run
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) digits = 16'($urandom);
            step($urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0, "random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule